// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block is the configuration front end of a multi-function I/O controller. It decodes a two-byte window on a simple byte-wide bus. The even byte of the window is an index register and the odd byte is a data register. The index selects one of three configuration registers, which are then read or written through the data byte. The three registers are a function-enable byte, a function-address byte and a power/test byte. They are driven out continuously, so that the serial, parallel, floppy and disk-interface decoders elsewhere in the chip can use them.

Reads of the index byte do not return the index straight away after reset. The first read returns an identification byte of 0x88 and the second returns 0x00. After that, reads return the selected index. Any write to the index ends this identification sequence at once. At reset the three registers take power-on values from a 32-entry table. A 5-bit strap input selects the table entry. This lets a board choose its default function layout without firmware.

Top module: `siocfg_port`

## Requirements
- R1: The window base is the parameter BASE_ADDR (default 0x398). An access is accepted only when bus_addr[15:1] equals BASE_ADDR[15:1]. bus_addr[0]=0 selects the index byte and bus_addr[0]=1 selects the data byte. Accesses outside the window change no state. bus_rdata is 0x00 whenever no read is accepted.
- R2: After reset, with no index write since, the first accepted index read returns 0x88.
- R3: The second index read after reset, with no index write in between, returns 0x00. Every index read after that returns the selected index, which is 0x00 after reset.
- R4: An index write stores the written byte as the selected index and ends the identification sequence. Every later index read returns that byte.
- R5: Selected index 0 maps to the function-enable register, index 1 to the function-address register and index 2 to the power/test register. A data write updates the chosen register on the clock edge that ends the write strobe. The new value then appears on its output and on data reads from the next cycle.
- R6: When the selected index is 3 or more, data writes change no register and data reads return 0x00.
- R7: Reset is synchronous and active high. It clears the selected index to 0, restarts the identification sequence and loads the three registers from the strap table. The table gives (enable, address, power) = (0x4F,0x10,0x00) for strap 0, (0x4F,0x11,0x00) for strap 1, (0x4B,0x00,0x00) for strap 6, (0x0F,0x10,0x00) for strap 12 and (0x00,0x10,0x02) for strap 31.
- R8: Data-byte reads and writes do not advance or end the identification sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 5 | Selects the power-on table entry; sampled during reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle the read strobe is high |
| fn_enable | output | 8 | Function-enable register |
| fn_address | output | 8 | Function-address register |
| pwr_test | output | 8 | Power/test register |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle, and they check this assumption. They also assume that each strobe lasts exactly one cycle per access, because an index read held high for several cycles steps the identification sequence once per cycle. The bench's bus tasks raise exactly one strobe for a single cycle and drop it before the next access. The bench holds the strap steady for the whole time reset is high. Some accesses go deliberately to addresses outside the window, to show that they leave the selected index and the registers alone.

// File: rtl/siocfg_pkg.sv
package siocfg_pkg;

    localparam int BYTE_W   = 8;
    localparam int STRAP_W  = 5;
    localparam int NUM_REGS = 3;
    localparam logic [BYTE_W-1:0] ID_BYTE = 8'h88;

    typedef enum logic [1:0] {
        ID_FIRST  = 2'd0,
        ID_SECOND = 2'd1,
        ID_DONE   = 2'd2
    } id_step_e;

    typedef struct packed {
        logic [BYTE_W-1:0] pwr;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] en;
    } cfg_regs_t;

    typedef struct packed {
        logic rd_idx;
        logic wr_idx;
        logic rd_dat;
        logic wr_dat;
    } acc_t;

    function automatic logic [BYTE_W-1:0] strap_enable(input logic [STRAP_W-1:0] s);
        if (s <= 5'd5)       return 8'h4F;
        else if (s <= 5'd11) return 8'h4B;
        else if (s <= 5'd15) return 8'h0F;
        else if (s <= 5'd19) return 8'h49;
        else if (s <= 5'd23) return 8'h07;
        else if (s <= 5'd29) return 8'h47;
        else if (s == 5'd30) return 8'h08;
        else                 return 8'h00;
    endfunction

    function automatic logic [BYTE_W-1:0] strap_address(input logic [STRAP_W-1:0] s);
        case (s)
            5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26: return 8'h11;
            5'd3, 5'd14, 5'd22, 5'd27:              return 8'h39;
            5'd4, 5'd15, 5'd23, 5'd28:              return 8'h24;
            5'd5, 5'd29:                            return 8'h38;
            5'd6, 5'd16, 5'd19:                     return 8'h00;
            5'd7, 5'd8, 5'd17, 5'd18:               return 8'h01;
            5'd9:                                   return 8'h09;
            5'd10, 5'd11:                           return 8'h08;
            default:                                return 8'h10;
        endcase
    endfunction

    function automatic cfg_regs_t strap_defaults(input logic [STRAP_W-1:0] s);
        cfg_regs_t r;
        r.en   = strap_enable(s);
        r.addr = strap_address(s);
        r.pwr  = (s == 5'd31) ? 8'h02 : 8'h00;
        return r;
    endfunction

endpackage

// File: rtl/siocfg_decode.sv
module siocfg_decode
    import siocfg_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0398
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output acc_t              acc
);
    logic hit;

    always_comb begin
        hit        = (addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
        acc.rd_idx = hit && rd && !addr[0];
        acc.wr_idx = hit && wr && !addr[0];
        acc.rd_dat = hit && rd &&  addr[0];
        acc.wr_dat = hit && wr &&  addr[0];
    end
endmodule

// File: rtl/siocfg_index.sv
module siocfg_index
    import siocfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_idx,
    input  logic              wr_idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] idx_q,
    output id_step_e          step_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            step_q <= ID_FIRST;
        end else if (wr_idx) begin
            idx_q  <= wdata;
            step_q <= ID_DONE;
        end else if (rd_idx && step_q != ID_DONE) begin
            step_q <= id_step_e'(step_q + 2'd1);
        end
    end

    // R4: an index write latches the byte and ends the ID sequence
    a_r4_index_latch: assert property (@(posedge clk) disable iff (rst)
        wr_idx |=> (idx_q == $past(wdata)) && (step_q == ID_DONE));

    // R3: the step never leaves its three legal values
    a_r3_step_legal: assert property (@(posedge clk) disable iff (rst)
        step_q != 2'd3);

    // R2: an index read at the first step moves to the second
    a_r2_step_advance: assert property (@(posedge clk) disable iff (rst)
        (rd_idx && !wr_idx && step_q == ID_FIRST) |=> step_q == ID_SECOND);

    // R8: without an index access the step holds
    a_r8_step_hold: assert property (@(posedge clk) disable iff (rst)
        (!rd_idx && !wr_idx) |=> $stable(step_q) && $stable(idx_q));
endmodule

// File: rtl/siocfg_regfile.sv
module siocfg_regfile
    import siocfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_dat,
    input  logic [BYTE_W-1:0]  idx,
    input  logic [BYTE_W-1:0]  wdata,
    output cfg_regs_t          regs_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= strap_defaults(strap);
        end else if (wr_dat) begin
            case (idx)
                8'd0:    regs_q.en   <= wdata;
                8'd1:    regs_q.addr <= wdata;
                8'd2:    regs_q.pwr  <= wdata;
                default: ;
            endcase
        end
    end

    // R6: data writes past the last register change nothing
    a_r6_no_write_oob: assert property (@(posedge clk) disable iff (rst)
        (wr_dat && idx >= 8'(NUM_REGS)) |=> $stable(regs_q));

    // R5: a write to index 1 lands in the address byte only
    a_r5_addr_write: assert property (@(posedge clk) disable iff (rst)
        (wr_dat && idx == 8'd1) |=> (regs_q.addr == $past(wdata))
                                    && $stable(regs_q.en) && $stable(regs_q.pwr));

    // R7: reset loads the strap table entry
    a_r7_reset_load: assert property (@(posedge clk)
        rst |=> regs_q == strap_defaults($past(strap)));
endmodule

// File: rtl/siocfg_port.sv
module siocfg_port
    import siocfg_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0398
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    output logic [BYTE_W-1:0]  fn_enable,
    output logic [BYTE_W-1:0]  fn_address,
    output logic [BYTE_W-1:0]  pwr_test
);
    acc_t              acc;
    logic [BYTE_W-1:0] idx;
    id_step_e          step;
    cfg_regs_t         regs;

    siocfg_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .acc  (acc)
    );

    siocfg_index u_idx (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (acc.rd_idx),
        .wr_idx (acc.wr_idx),
        .wdata  (bus_wdata),
        .idx_q  (idx),
        .step_q (step)
    );

    siocfg_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .strap  (strap),
        .wr_dat (acc.wr_dat),
        .idx    (idx),
        .wdata  (bus_wdata),
        .regs_q (regs)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc.rd_idx) begin
            case (step)
                ID_FIRST:  bus_rdata = ID_BYTE;
                ID_SECOND: bus_rdata = '0;
                default:   bus_rdata = idx;
            endcase
        end else if (acc.rd_dat) begin
            case (idx)
                8'd0:    bus_rdata = regs.en;
                8'd1:    bus_rdata = regs.addr;
                8'd2:    bus_rdata = regs.pwr;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign fn_enable  = regs.en;
    assign fn_address = regs.addr;
    assign pwr_test   = regs.pwr;

    // Input assumption: one strobe at a time
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R1: accesses outside the window leave all state alone
    a_r1_miss_ignored: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && bus_addr[ADDR_W-1:1] != BASE_ADDR[ADDR_W-1:1])
        |=> $stable(fn_enable) && $stable(fn_address) && $stable(pwr_test));

    // R1: no accepted read, no data on the bus
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == 8'h00);
endmodule

// File: tb/sim_siocfg_port.sv
module sim_siocfg_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] IDX_A = 16'h0398;
    localparam logic [15:0] DAT_A = 16'h0399;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  strap = 5'd1;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata, fn_enable, fn_address, pwr_test;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    siocfg_port u0 (
        .clk(clk), .rst(rst), .strap(strap), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fn_enable(fn_enable),
        .fn_address(fn_address), .pwr_test(pwr_test)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected byte per read strobe
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: got %02h expected none", bus_rdata);
            end else begin
                check_eq(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic do_reset(input logic [4:0] s);
        @(posedge clk); #1;
        strap = s; rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic check_regs(input string tag, input logic [7:0] e, input logic [7:0] a,
                              input logic [7:0] p);
        @(negedge clk);
        check_eq({tag, " enable"}, fn_enable, e);
        check_eq({tag, " address"}, fn_address, a);
        check_eq({tag, " power"}, pwr_test, p);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R7 strap 1 reset values, then ID sequence
        do_reset(5'd1);
        check_regs("R7 strap1", 8'h4F, 8'h11, 8'h00);
        check_eq("R1 idle rdata", bus_rdata, 8'h00);
        bus_read(IDX_A, 8'h88, "R2 first id read");
        bus_read(IDX_A, 8'h00, "R3 second id read");
        bus_read(IDX_A, 8'h00, "R3 third read index");
        bus_read(DAT_A, 8'h4F, "R5 read enable");

        // R8: data accesses do not advance the ID sequence
        do_reset(5'd1);
        bus_read(DAT_A, 8'h4F, "R8 data read");
        bus_write(DAT_A, 8'h4F);
        bus_read(IDX_A, 8'h88, "R8 id still first");

        // R4: index write ends ID sequence
        do_reset(5'd1);
        bus_write(IDX_A, 8'h01);
        bus_read(IDX_A, 8'h01, "R4 index readback");
        bus_read(DAT_A, 8'h11, "R5 read address");

        // R5 writes to each register
        bus_write(DAT_A, 8'h5A);
        check_regs("R5 addr write", 8'h4F, 8'h5A, 8'h00);
        bus_read(DAT_A, 8'h5A, "R5 addr readback");
        bus_write(IDX_A, 8'h02);
        bus_write(DAT_A, 8'hC3);
        check_regs("R5 power write", 8'h4F, 8'h5A, 8'hC3);
        bus_read(DAT_A, 8'hC3, "R5 power readback");
        bus_write(IDX_A, 8'h00);
        bus_write(DAT_A, 8'h81);
        check_regs("R5 enable write", 8'h81, 8'h5A, 8'hC3);
        bus_read(DAT_A, 8'h81, "R5 enable readback");

        // R6 index 3 and 0xFF
        bus_write(IDX_A, 8'h03);
        bus_write(DAT_A, 8'hFF);
        check_regs("R6 idx3 write", 8'h81, 8'h5A, 8'hC3);
        bus_read(DAT_A, 8'h00, "R6 idx3 read");
        bus_read(IDX_A, 8'h03, "R4 index 3 readback");
        bus_write(IDX_A, 8'hFF);
        bus_write(DAT_A, 8'h12);
        check_regs("R6 idxFF write", 8'h81, 8'h5A, 8'hC3);
        bus_read(DAT_A, 8'h00, "R6 idxFF read");

        // R1 accesses outside the window
        bus_write(IDX_A, 8'h01);
        bus_write(16'h039A, 8'h00);
        bus_write(16'h0399 ^ 16'h0100, 8'h77);
        bus_write(16'h039B, 8'h66);
        check_regs("R1 miss write", 8'h81, 8'h5A, 8'hC3);
        bus_read(IDX_A, 8'h01, "R1 index kept");
        bus_read(16'h039B, 8'h00, "R1 miss read");
        bus_read(16'h0299, 8'h00, "R1 miss read high");

        // R7 other strap entries and reset mid-sequence
        do_reset(5'd0);
        check_regs("R7 strap0", 8'h4F, 8'h10, 8'h00);
        bus_read(IDX_A, 8'h88, "R2 after strap0 reset");
        do_reset(5'd31);
        check_regs("R7 strap31", 8'h00, 8'h10, 8'h02);
        bus_read(IDX_A, 8'h88, "R7 id restarts");
        bus_read(IDX_A, 8'h00, "R3 second after reset");
        bus_read(DAT_A, 8'h00, "R7 index cleared reads enable");
        do_reset(5'd6);
        check_regs("R7 strap6", 8'h4B, 8'h00, 8'h00);
        do_reset(5'd12);
        check_regs("R7 strap12", 8'h0F, 8'h10, 8'h00);

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard drain: got %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule